// File: doc/BRIEF.md
# Oversampling UART Receiver with Receive FIFO

This block recovers bytes from an asynchronous serial line. A one-cycle enable pulse arrives at sixteen times the bit rate. On each pulse the block takes one sample of the synchronized line. A falling edge between two such samples opens a frame. Each bit of the frame (the start bit, eight data bits and the stop bit) is then decided by a two-of-three vote over the seventh, eighth and ninth of its sixteen samples. The frame format is fixed: one start bit, eight data bits sent least significant bit first, one stop bit and no parity.

A frame with a good stop bit pushes its byte into an eight-word first-in first-out store. The host sees the oldest byte on the read data port while the data-available flag is high, and consumes it with a one-cycle pop strobe. A frame that completes while the store is already full wipes the whole store and raises a sticky overflow flag. A frame whose stop bit votes low raises a sticky framing-error flag. A pop strobe clears both flags.

Top module: `uart_rx_fifo`

## Requirements
- R1: After reset, data_avail, overflow and frame_err are all 0.
- R2: The line is sampled only on cycles where tick16 is 1. A frame begins when one tick sample is 1 and the next tick sample is 0. Frames are received correctly whatever the phase of the start edge relative to tick16, so detection may be up to one tick late.
- R3: Each bit value is the majority of its 7th, 8th and 9th tick samples, counted from the detection sample as sample 1. A glitch one tick wide inside a bit does not change the received byte.
- R4: If the start bit votes 1, the receiver returns to idle. Nothing is stored and no flag changes.
- R5: The eight data bits are assembled LSB first, with the first bit after the start bit becoming bit 0. A stop bit that votes 1 pushes the byte into the FIFO.
- R6: A stop bit that votes 0 sets frame_err. The byte is not stored, and frame_err stays 1 until a pop or reset.
- R7: The FIFO holds up to 8 bytes in arrival order. rd_data shows the oldest byte, and data_avail is 1 exactly when the FIFO is not empty. A pop while the FIFO is empty has no effect.
- R8: A byte that completes while the FIFO holds 8 bytes and no pop is made in that cycle empties the FIFO, is itself discarded, and sets overflow. Eight bytes in a row do not set overflow.
- R9: A pop strobe clears overflow and frame_err, unless a new event sets the flag in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick16 | input | 1 | One-cycle enable at 16 times the bit rate |
| rx | input | 1 | Asynchronous serial input, idle high |
| pop | input | 1 | Removes the oldest byte and clears the sticky flags |
| rd_data | output | 8 | Oldest stored byte, valid while data_avail is 1 |
| data_avail | output | 1 | FIFO is not empty |
| overflow | output | 1 | Sticky: a byte arrived while the FIFO was full |
| frame_err | output | 1 | Sticky: a stop bit was received as 0 |

## Verification
The bench shifts each start edge across all four clock phases of the tick period. A receiver that tied its bit count to the true edge, and not to the detection sample, would drift into bit edges and corrupt bytes. It places one-tick glitches at bit centres, where a design that takes a single sample instead of a vote returns wrong bytes. It also sends short low pulses that a design with no start-bit check would turn into phantom bytes. At the FIFO boundary it fills exactly eight bytes, which must not flag overflow, and then nine, which must leave the store empty with overflow set. An off-by-one full test, or dropping only the new byte, shows up as stale data or a missing flag. It also sends a frame with a low stop bit, which must raise frame_err and store nothing, and pops an empty FIFO, which must change nothing.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/urx_reset_sync.sv
module urx_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/urx_line_sync.sv
module urx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
    end
  end

  assign dout = sync_q[STAGES-1];

endmodule

// File: rtl/urx_deframer.sv
module urx_deframer
  import uart_rx_pkg::*;
#(
  parameter int OSR       = 16,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 rx_s,
  output logic                 push,
  output logic [DATA_BITS-1:0] push_data,
  output logic                 ferr_set
);

  localparam int CW      = $clog2(OSR);
  localparam int BW      = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam int VOTE_A  = OSR / 2 - 2;
  localparam int VOTE_B  = OSR / 2 - 1;
  localparam int VOTE_C  = OSR / 2;

  rx_state_e            state_q, state_d;
  logic [CW-1:0]        cnt_q, cnt_d;
  logic [BW-1:0]        bit_q, bit_d;
  logic [DATA_BITS-1:0] shift_q, shift_d;
  logic [1:0]           votes_q, votes_d;
  logic                 last_q, last_d;
  logic                 vote;

  assign vote = maj3(votes_q[0], votes_q[1], rx_s);

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    bit_d    = bit_q;
    shift_d  = shift_q;
    votes_d  = votes_q;
    last_d   = last_q;
    push     = 1'b0;
    ferr_set = 1'b0;
    if (tick) begin
      last_d = rx_s;
      if (state_q == ST_IDLE) begin
        if (last_q && !rx_s) begin
          state_d = ST_START;
          cnt_d   = CW'(1);
        end
      end else begin
        if (cnt_q == CW'(OSR - 1)) begin
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
        if (cnt_q == CW'(VOTE_A)) begin
          votes_d[0] = rx_s;
        end
        if (cnt_q == CW'(VOTE_B)) begin
          votes_d[1] = rx_s;
        end
        if (cnt_q == CW'(VOTE_C)) begin
          case (state_q)
            ST_START: begin
              if (vote) begin
                state_d = ST_IDLE;
              end
            end
            ST_DATA: begin
              shift_d = {vote, shift_q[DATA_BITS-1:1]};
            end
            ST_STOP: begin
              if (vote) begin
                push = 1'b1;
              end else begin
                ferr_set = 1'b1;
              end
              state_d = ST_IDLE;
            end
            default: ;
          endcase
        end
        if (cnt_q == CW'(OSR - 1)) begin
          case (state_q)
            ST_START: begin
              state_d = ST_DATA;
              bit_d   = '0;
            end
            ST_DATA: begin
              if (bit_q == BW'(DATA_BITS - 1)) begin
                state_d = ST_STOP;
              end else begin
                bit_d = bit_q + 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      shift_q <= '0;
      votes_q <= '0;
      last_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      shift_q <= shift_d;
      votes_q <= votes_d;
      last_q  <= last_d;
    end
  end

  assign push_data = shift_q;

  // R2: without a tick the idle receiver never leaves idle
  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !tick) |=> (state_q == ST_IDLE));

  // R2: a frame opens only on a tick that sees the line low
  a_r2_start_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && tick && rx_s) |=> (state_q == ST_IDLE));

  // R5: after a byte is delivered the receiver is idle again
  a_r5_push_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (state_q == ST_IDLE));

  // R6: a byte is never stored and flagged as bad in the same cycle
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && ferr_set));

endmodule

// File: rtl/urx_fifo.sv
module urx_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] rd_data,
  output logic         not_empty,
  output logic         ovf_evt
);

  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [W-1:0]    mem_q [DEPTH];
  logic [AW-1:0]   wr_q, wr_d, rd_q, rd_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            full, do_pop, do_push;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) begin
      return '0;
    end
    return p + 1'b1;
  endfunction

  assign full    = (cnt_q == CNTW'(DEPTH));
  assign do_pop  = pop && (cnt_q != '0);
  assign ovf_evt = push && full && !do_pop;
  assign do_push = push && !ovf_evt;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (ovf_evt) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) begin
        wr_d = ptr_inc(wr_q);
      end
      if (do_pop) begin
        rd_d = ptr_inc(rd_q);
      end
      if (do_push && !do_pop) begin
        cnt_d = cnt_q + 1'b1;
      end else if (do_pop && !do_push) begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) begin
      mem_q[wr_q] <= push_data;
    end
  end

  assign rd_data   = mem_q[rd_q];
  assign not_empty = (cnt_q != '0);

  // R7: occupancy never exceeds the depth
  a_r7_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNTW'(DEPTH));

  // R7: a push into an empty store makes data available next cycle
  a_r7_push_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (push && cnt_q == '0) |=> not_empty);

  // R7: popping an empty store leaves it empty
  a_r7_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && cnt_q == '0) |=> (cnt_q == '0));

  // R8: a push into a full store with no pop empties it
  a_r8_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && cnt_q == CNTW'(DEPTH)) |=> !not_empty);

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int OSR         = 16,
  parameter int DATA_BITS   = 8,
  parameter int FIFO_DEPTH  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick16,
  input  logic                 rx,
  input  logic                 pop,
  output logic [DATA_BITS-1:0] rd_data,
  output logic                 data_avail,
  output logic                 overflow,
  output logic                 frame_err
);

  logic                 rst_n_i;
  logic                 rx_s;
  logic                 push;
  logic [DATA_BITS-1:0] push_data;
  logic                 ferr_set;
  logic                 ovf_evt;
  logic                 ovf_q, ovf_d, ferr_q, ferr_d;

  urx_reset_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  urx_line_sync #(.STAGES(SYNC_STAGES)) i_line_sync (
    .clk   (clk),
    .rst_n (rst_n_i),
    .din   (rx),
    .dout  (rx_s)
  );

  urx_deframer #(.OSR(OSR), .DATA_BITS(DATA_BITS)) i_deframer (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .tick      (tick16),
    .rx_s      (rx_s),
    .push      (push),
    .push_data (push_data),
    .ferr_set  (ferr_set)
  );

  urx_fifo #(.DEPTH(FIFO_DEPTH), .W(DATA_BITS)) i_fifo (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .push      (push),
    .push_data (push_data),
    .pop       (pop),
    .rd_data   (rd_data),
    .not_empty (data_avail),
    .ovf_evt   (ovf_evt)
  );

  always_comb begin
    ovf_d  = ovf_q;
    ferr_d = ferr_q;
    if (pop) begin
      ovf_d  = 1'b0;
      ferr_d = 1'b0;
    end
    if (ovf_evt) begin
      ovf_d = 1'b1;
    end
    if (ferr_set) begin
      ferr_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ovf_q  <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      ovf_q  <= ovf_d;
      ferr_q <= ferr_d;
    end
  end

  assign overflow  = ovf_q;
  assign frame_err = ferr_q;

  // R8: an overflow event is visible on the flag the next cycle
  a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n_i)
    ovf_evt |=> overflow);

  // R9: a pop with no fresh overflow clears the flag
  a_r9_ovf_clear: assert property (@(posedge clk) disable iff (!rst_n_i)
    (pop && !ovf_evt) |=> !overflow);

  // R9: a pop with no fresh framing error clears that flag
  a_r9_ferr_clear: assert property (@(posedge clk) disable iff (!rst_n_i)
    (pop && !ferr_set) |=> !frame_err);

  // R6: the framing flag holds without a pop
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n_i)
    (frame_err && !pop) |=> frame_err);

endmodule

// File: tb/test_uart_rx_fifo.sv
`timescale 1ns/1ps
module test_uart_rx_fifo;

  localparam int TICK_DIV = 4;
  localparam int BIT_CLKS = 16 * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       rx = 1'b1;
  logic       pop = 1'b0;
  logic [7:0] rd_data;
  logic       data_avail, overflow, frame_err;

  int   tests = 0;
  int   fails = 0;
  bit   mon_en = 1'b0;
  bit   done = 1'b0;
  logic [7:0] exp_q [$];

  uart_rx_fifo i_uart_rx_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick16     (tick16),
    .rx         (rx),
    .pop        (pop),
    .rd_data    (rd_data),
    .data_avail (data_avail),
    .overflow   (overflow),
    .frame_err  (frame_err)
  );

  always #2.5 clk = ~clk;

  initial begin
    forever begin
      for (int i = 0; i < TICK_DIV; i++) begin
        @(negedge clk);
        tick16 = (i == 0);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // glitch_bit: data bit index to receive a one-tick pulse at its centre, -1 for none
  task automatic drive_frame(input logic [7:0] b, input logic stop, input int glitch_bit);
    logic [9:0] bits;
    bits = {stop, b, 1'b0};
    for (int k = 0; k < 10; k++) begin
      for (int c = 0; c < BIT_CLKS; c++) begin
        @(negedge clk);
        rx = bits[k];
        if (k == glitch_bit + 1 && glitch_bit >= 0 && c >= 30 && c < 30 + TICK_DIV) begin
          rx = ~bits[k];
        end
      end
    end
    @(negedge clk);
    rx = 1'b1;
    wait_clks(BIT_CLKS);
  endtask

  task automatic send_byte(input logic [7:0] b, input int glitch_bit);
    exp_q.push_back(b);
    drive_frame(b, 1'b1, glitch_bit);
  endtask

  task automatic pulse_pop();
    @(negedge clk);
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    @(negedge clk);
  endtask

  // monitor: pops and compares against the scoreboard queue
  initial begin
    logic [7:0] e;
    forever begin
      @(negedge clk);
      if (mon_en && data_avail) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4/R5 unexpected byte", int'(rd_data), 0);
        end else begin
          e = exp_q.pop_front();
          check(rd_data == e, "R5/R7 byte order and value", int'(rd_data), int'(e));
        end
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    wait_clks(5);
    check(!data_avail && !overflow && !frame_err, "R1 reset state",
          {data_avail, overflow, frame_err}, 0);
    rst_n = 1'b1;
    wait_clks(10);
    check(!data_avail && !overflow && !frame_err, "R1 after release",
          {data_avail, overflow, frame_err}, 0);

    // R5, R2: basic bytes with start edges at every clock phase of the tick
    mon_en = 1'b1;
    for (int p = 0; p < TICK_DIV; p++) begin
      wait_clks(p + 3);
      send_byte(8'hA5 ^ 8'(p * 37), -1);
    end
    send_byte(8'h01, -1);
    send_byte(8'h80, -1);
    send_byte(8'hFF, -1);
    send_byte(8'h00, -1);
    wait_clks(20);
    check(exp_q.size() == 0, "R2 phase sweep all received", exp_q.size(), 0);

    // R3: one-tick glitch in each data bit centre
    for (int g = 0; g < 8; g++) begin
      send_byte(8'h3C ^ 8'(1 << g), g);
    end
    wait_clks(20);
    check(exp_q.size() == 0, "R3 glitch-tolerant bytes", exp_q.size(), 0);

    // R4: short low pulse is a false start
    @(negedge clk);
    rx = 1'b0;
    wait_clks(2 * TICK_DIV);
    rx = 1'b1;
    wait_clks(12 * BIT_CLKS);
    check(!data_avail && !frame_err && !overflow, "R4 false start ignored",
          {data_avail, frame_err, overflow}, 0);
    send_byte(8'h5A, -1);
    wait_clks(20);
    check(exp_q.size() == 0, "R4 receiver recovers after false start", exp_q.size(), 0);

    // R6: low stop bit
    mon_en = 1'b0;
    drive_frame(8'h77, 1'b0, -1);
    wait_clks(10);
    check(frame_err == 1'b1, "R6 frame_err set", frame_err, 1);
    check(!data_avail, "R6 bad byte not stored", data_avail, 0);
    wait_clks(3 * BIT_CLKS);
    check(frame_err == 1'b1, "R6 frame_err sticky", frame_err, 1);
    pulse_pop();
    check(frame_err == 1'b0, "R9 pop clears frame_err", frame_err, 0);

    // R7: pop on empty changes nothing
    pulse_pop();
    check(!data_avail && !overflow, "R7 pop on empty", {data_avail, overflow}, 0);

    // R8: exactly eight bytes fit
    for (int n = 0; n < 8; n++) begin
      send_byte(8'(8'h10 + n), -1);
    end
    wait_clks(10);
    check(data_avail == 1'b1, "R7 data_avail with full store", data_avail, 1);
    check(overflow == 1'b0, "R8 eight bytes no overflow", overflow, 0);
    check(rd_data == 8'h10, "R7 head is oldest", int'(rd_data), 8'h10);
    mon_en = 1'b1;
    wait_clks(60);
    check(exp_q.size() == 0, "R7 all eight drained", exp_q.size(), 0);
    check(!data_avail, "R7 empty after drain", data_avail, 0);

    // R8: ninth byte flushes
    mon_en = 1'b0;
    for (int n = 0; n < 9; n++) begin
      drive_frame(8'(8'hC0 + n), 1'b1, -1);
    end
    wait_clks(10);
    check(overflow == 1'b1, "R8 overflow set", overflow, 1);
    check(!data_avail, "R8 store flushed", data_avail, 0);
    wait_clks(BIT_CLKS);
    check(overflow == 1'b1, "R8 overflow sticky", overflow, 1);
    pulse_pop();
    check(overflow == 1'b0, "R9 pop clears overflow", overflow, 0);

    mon_en = 1'b1;
    send_byte(8'h9E, -1);
    wait_clks(20);
    check(exp_q.size() == 0, "R8 receive resumes after flush", exp_q.size(), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule